// File: doc/BRIEF.md
# Strided Two-Dimensional Burst Request Generator

This block accepts one transfer descriptor at a time and expands it into a stream of memory-mapped burst requests. The descriptor describes a rectangle in memory: a source and a destination base address, a row length and a row count (both written as the value minus one), and a separate row stride for each side. The block visits the rows in ascending order. Each row is cut into bursts of at most a fixed byte limit. Every request carries a source address, a destination address, a beat count, a byte mask for the final beat, and two flags that mark the end of a row and the end of the transfer.

The byte limit is derived from parameters. It is the configured burst size, capped by the largest beat count the selected bus protocol allows. A cyclic descriptor repeats the whole rectangle until the enable input falls. An ordinary descriptor ends with a one-cycle completion pulse. When enable falls, the request already on the output is still handed over, and nothing is issued after it. The stop therefore takes effect between bursts.

Top module: `burst_walk2d`

## Requirements
- R1: With two-dimensional mode on, each row moves exactly row_len_m1+1 bytes and the transfer covers row_cnt_m1+1 rows.
- R2: The first burst of row N starts at aligned_base + N * aligned_stride, computed separately for the source and destination sides. Later bursts in the same row follow each other contiguously.
- R3: When the parameter EN_2D is 0, the row count input is ignored and exactly one row is moved.
- R4: Address bits below log2(DATA_BYTES) are cleared in both base addresses and both strides before use.
- R5: The burst byte limit is DATA_BYTES times the smaller of MAX_BURST_BYTES/DATA_BYTES and the protocol beat cap. PROTO=0 caps at 256 beats, PROTO=1 at 16 and PROTO=2 at 1024. A row becomes full-size bursts followed by one final burst of ceil(remaining/DATA_BYTES) beats.
- R6: req_strb bit i enables byte lane i of the last beat. On the final burst of a row, with k = row bytes mod DATA_BYTES, the low k bits are set if k is nonzero and all bits are set if k is zero. Every other burst has all bits set. req_row_end is high on the last burst of each row, and req_xfer_end is high on the last burst of the last row.
- R7: With the cyclic flag set, the burst after the final one restarts at the first row with the same settings, and xfer_done never rises.
- R8: While enable is low, no descriptor is accepted. Once the request on the output has been accepted, no further request is issued.
- R9: While req_valid is high and req_ready is low, req_valid and every request field stay unchanged.
- R10: After the final burst of a non-cyclic transfer is accepted, xfer_done is high for exactly one cycle.
- R11: After reset, req_valid and xfer_done are low, and desc_ready follows enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows descriptor acceptance and further bursts |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken (idle and enabled) |
| desc_src_base | input | ADDR_W | Source base address |
| desc_dst_base | input | ADDR_W | Destination base address |
| desc_row_len_m1 | input | LEN_W | Bytes per row minus one |
| desc_row_cnt_m1 | input | ROWS_W | Rows minus one |
| desc_src_stride | input | ADDR_W | Source distance between row starts |
| desc_dst_stride | input | ADDR_W | Destination distance between row starts |
| desc_cyclic | input | 1 | Repeat the transfer until disabled |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Burst request taken |
| req_src_addr | output | ADDR_W | Burst source address |
| req_dst_addr | output | ADDR_W | Burst destination address |
| req_beats | output | BEAT_W | Beats in the burst (1..limit) |
| req_strb | output | DATA_BYTES | Byte enables of the last beat |
| req_row_end | output | 1 | Last burst of a row |
| req_xfer_end | output | 1 | Last burst of the transfer |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The main instance is built with 4-byte beats, a 128-byte configured burst and PROTO=1. The 16-beat cap then cuts bursts to 64 bytes, which exercises the protocol limit rather than the configured size. A second instance uses EN_2D=0, PROTO=2 and 16-byte bursts, which shows the ignored row count and short rows split into several bursts. Row lengths are chosen to give partial final beats, exact multiples and single-byte rows. The tests also cover uneven ready patterns, cyclic wrap-around, and disabling the block in the middle of a transfer.

// File: rtl/bw_pkg.sv
package bw_pkg;

  typedef enum logic {
    BW_IDLE = 1'b0,
    BW_RUN  = 1'b1
  } bw_state_t;

  // Largest beat count per burst for each protocol selection
  function automatic int bw_proto_cap(input int proto);
    case (proto)
      0:       return 256;
      1:       return 16;
      default: return 1024;
    endcase
  endfunction

  function automatic int bw_min(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/bw_addr_lane.sv
module bw_addr_lane #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int STEP_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              restart,
  input  logic              step_row,
  input  logic              step_burst,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] base_q, stride_q, row_q, cur_q;
  logic [ADDR_W-1:0] next_row;

  assign next_row = row_q + stride_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      stride_q <= '0;
      row_q    <= '0;
      cur_q    <= '0;
    end else if (load) begin
      base_q   <= base & ~LOW_MASK;
      stride_q <= stride & ~LOW_MASK;
      row_q    <= base & ~LOW_MASK;
      cur_q    <= base & ~LOW_MASK;
    end else if (restart) begin
      row_q <= base_q;
      cur_q <= base_q;
    end else if (step_row) begin
      row_q <= next_row;
      cur_q <= next_row;
    end else if (step_burst) begin
      cur_q <= cur_q + STEP;
    end
  end

  assign addr = cur_q;

  // R4: emitted addresses never carry sub-beat bits
  assert_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_q & LOW_MASK) == '0);

  // R7: a restart returns the lane to the stored base
  assert_restart_base_R7: assert property (@(posedge clk) disable iff (rst)
    (restart && !load) |=> (cur_q == $past(base_q)));

endmodule

// File: rtl/bw_burst_size.sv
module bw_burst_size #(
  parameter int LEN_W      = 16,
  parameter int DATA_BYTES = 8,
  parameter int EFF_BEATS  = 32,
  parameter int BEAT_W     = 6
) (
  input  logic [LEN_W:0]          rem,
  output logic [BEAT_W-1:0]       beats,
  output logic [DATA_BYTES-1:0]   strb,
  output logic                    row_end
);

  localparam int          SHIFT     = $clog2(DATA_BYTES);
  localparam logic [31:0] EFF_BYTES = 32'(EFF_BEATS * DATA_BYTES);
  localparam logic [31:0] LANE_MASK = 32'(DATA_BYTES - 1);

  logic [31:0] rem32;
  logic [31:0] tail;

  assign rem32 = 32'(rem);
  assign tail  = rem32 & LANE_MASK;

  always_comb begin
    if (rem32 > EFF_BYTES) begin
      beats   = BEAT_W'(EFF_BEATS);
      strb    = '1;
      row_end = 1'b0;
    end else begin
      beats   = BEAT_W'((rem32 + LANE_MASK) >> SHIFT);
      row_end = 1'b1;
      for (int i = 0; i < DATA_BYTES; i++) begin
        strb[i] = (tail == 32'd0) || (32'(i) < tail);
      end
    end
  end

endmodule

// File: rtl/burst_walk2d.sv
module burst_walk2d #(
  parameter int ADDR_W          = 32,
  parameter int LEN_W           = 16,
  parameter int ROWS_W          = 10,
  parameter int DATA_BYTES      = 8,
  parameter int MAX_BURST_BYTES = 256,
  parameter int PROTO           = 0,
  parameter int EN_2D           = 1,
  localparam int ALIGN_BITS     = $clog2(DATA_BYTES),
  localparam int EFF_BEATS      = bw_pkg::bw_min(MAX_BURST_BYTES / DATA_BYTES,
                                                 bw_pkg::bw_proto_cap(PROTO)),
  localparam int EFF_BYTES      = EFF_BEATS * DATA_BYTES,
  localparam int BEAT_W         = $clog2(EFF_BEATS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  desc_valid,
  output logic                  desc_ready,
  input  logic [ADDR_W-1:0]     desc_src_base,
  input  logic [ADDR_W-1:0]     desc_dst_base,
  input  logic [LEN_W-1:0]      desc_row_len_m1,
  input  logic [ROWS_W-1:0]     desc_row_cnt_m1,
  input  logic [ADDR_W-1:0]     desc_src_stride,
  input  logic [ADDR_W-1:0]     desc_dst_stride,
  input  logic                  desc_cyclic,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_src_addr,
  output logic [ADDR_W-1:0]     req_dst_addr,
  output logic [BEAT_W-1:0]     req_beats,
  output logic [DATA_BYTES-1:0] req_strb,
  output logic                  req_row_end,
  output logic                  req_xfer_end,
  output logic                  xfer_done
);

  import bw_pkg::*;

  localparam int REM_W   = LEN_W + 1;
  localparam int N_LANES = 2;

  bw_state_t              state_q;
  logic [LEN_W-1:0]       len_q;
  logic [ROWS_W-1:0]      rows_q, row_idx_q, row_idx_n, rows_in;
  logic                   cyc_q;
  logic [REM_W-1:0]       rem_q, rem_n;
  logic                   valid_q, done_q, row_end_q, xfer_end_q;
  logic [BEAT_W-1:0]      beats_q, beats_n;
  logic [DATA_BYTES-1:0]  strb_q, strb_n;
  logic                   row_end_n;
  logic                   accept, fire, stop_n, go, last_row;
  logic                   lane_step_burst, lane_step_row, lane_restart;

  // Row count source: ignored entirely when the 2D walk is disabled
  generate
    if (EN_2D != 0) begin : g_rows_2d
      assign rows_in = desc_row_cnt_m1;
    end else begin : g_rows_flat
      logic unused_rows;
      assign unused_rows = ^desc_row_cnt_m1;
      assign rows_in     = '0;
    end
  endgenerate

  assign desc_ready = (state_q == BW_IDLE) && enable;
  assign accept     = desc_ready && desc_valid;
  assign fire       = valid_q && req_ready;
  assign last_row   = (row_idx_q == rows_q);
  assign stop_n     = (xfer_end_q && !cyc_q) || !enable;
  assign go         = fire && !stop_n;

  assign lane_step_burst = go && !row_end_q;
  assign lane_step_row   = go && row_end_q && !last_row;
  assign lane_restart    = go && row_end_q && last_row;

  // Bytes left in the row for the burst about to be presented
  always_comb begin
    if (state_q == BW_IDLE)
      rem_n = {1'b0, desc_row_len_m1} + REM_W'(1);
    else if (row_end_q)
      rem_n = {1'b0, len_q} + REM_W'(1);
    else
      rem_n = rem_q - REM_W'(EFF_BYTES);
  end

  always_comb begin
    if (row_end_q)
      row_idx_n = last_row ? '0 : row_idx_q + ROWS_W'(1);
    else
      row_idx_n = row_idx_q;
  end

  bw_burst_size #(
    .LEN_W      (LEN_W),
    .DATA_BYTES (DATA_BYTES),
    .EFF_BEATS  (EFF_BEATS),
    .BEAT_W     (BEAT_W)
  ) size_i (
    .rem     (rem_n),
    .beats   (beats_n),
    .strb    (strb_n),
    .row_end (row_end_n)
  );

  // Source and destination address lanes share one structure
  logic [ADDR_W-1:0] lane_base   [N_LANES];
  logic [ADDR_W-1:0] lane_stride [N_LANES];
  logic [ADDR_W-1:0] lane_addr   [N_LANES];

  assign lane_base[0]   = desc_src_base;
  assign lane_stride[0] = desc_src_stride;
  assign lane_base[1]   = desc_dst_base;
  assign lane_stride[1] = desc_dst_stride;

  generate
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      bw_addr_lane #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS),
        .STEP_BYTES (EFF_BYTES)
      ) lane_i (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .restart    (lane_restart),
        .step_row   (lane_step_row),
        .step_burst (lane_step_burst),
        .base       (lane_base[g]),
        .stride     (lane_stride[g]),
        .addr       (lane_addr[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= BW_IDLE;
      valid_q    <= 1'b0;
      done_q     <= 1'b0;
      len_q      <= '0;
      rows_q     <= '0;
      row_idx_q  <= '0;
      cyc_q      <= 1'b0;
      rem_q      <= '0;
      beats_q    <= '0;
      strb_q     <= '0;
      row_end_q  <= 1'b0;
      xfer_end_q <= 1'b0;
    end else begin
      done_q <= fire && xfer_end_q && !cyc_q;
      case (state_q)
        BW_IDLE: begin
          if (accept) begin
            state_q    <= BW_RUN;
            valid_q    <= 1'b1;
            len_q      <= desc_row_len_m1;
            rows_q     <= rows_in;
            cyc_q      <= desc_cyclic;
            row_idx_q  <= '0;
            rem_q      <= rem_n;
            beats_q    <= beats_n;
            strb_q     <= strb_n;
            row_end_q  <= row_end_n;
            xfer_end_q <= row_end_n && (rows_in == '0);
          end
        end
        default: begin
          if (fire) begin
            if (stop_n) begin
              state_q <= BW_IDLE;
              valid_q <= 1'b0;
            end else begin
              row_idx_q  <= row_idx_n;
              rem_q      <= rem_n;
              beats_q    <= beats_n;
              strb_q     <= strb_n;
              row_end_q  <= row_end_n;
              xfer_end_q <= row_end_n && (row_idx_n == rows_q);
            end
          end
        end
      endcase
    end
  end

  assign req_valid    = valid_q;
  assign req_src_addr = lane_addr[0];
  assign req_dst_addr = lane_addr[1];
  assign req_beats    = beats_q;
  assign req_strb     = strb_q;
  assign req_row_end  = row_end_q;
  assign req_xfer_end = xfer_end_q;
  assign xfer_done    = done_q;

  // R9: a stalled request holds every field
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src_addr) &&
      $stable(req_dst_addr) && $stable(req_beats) && $stable(req_strb) &&
      $stable(req_row_end) && $stable(req_xfer_end)));

  // R8: with enable low, the accepted request is the last one
  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !enable) |=> !req_valid);

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R5: beat counts stay inside the effective limit
  assert_beats_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_beats != '0 && 32'(req_beats) <= 32'(EFF_BEATS)));

  // R11: no request while a descriptor can be taken
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !req_valid);

  // R7: cyclic transfers keep producing while enabled
  assert_cyclic_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && req_xfer_end && cyc_q && enable) |=> (req_valid && !xfer_done));

endmodule

// File: tb/burst_walk2d_tb_top.sv
module burst_walk2d_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  logic        enable = 1'b1;
  logic [31:0] d_src = '0, d_dst = '0, d_ss = '0, d_ds = '0;
  logic [11:0] d_len = '0;
  logic [5:0]  d_cnt = '0;
  logic        d_cyc = 1'b0;
  logic        m_dv = 1'b0, f_dv = 1'b0;
  logic        m_rdy = 1'b0, f_rdy = 1'b0;
  logic        sel = 1'b0;

  logic        m_dr, m_v, m_re, m_xe, m_done;
  logic [31:0] m_sa, m_da;
  logic [4:0]  m_bt;
  logic [3:0]  m_st;
  logic        f_dr, f_v, f_re, f_xe, f_done;
  logic [31:0] f_sa, f_da;
  logic [2:0]  f_bt;
  logic [3:0]  f_st;

  burst_walk2d #(.ADDR_W(32), .LEN_W(12), .ROWS_W(6), .DATA_BYTES(4),
                 .MAX_BURST_BYTES(128), .PROTO(1), .EN_2D(1)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .desc_valid(m_dv), .desc_ready(m_dr),
    .desc_src_base(d_src), .desc_dst_base(d_dst), .desc_row_len_m1(d_len),
    .desc_row_cnt_m1(d_cnt), .desc_src_stride(d_ss), .desc_dst_stride(d_ds),
    .desc_cyclic(d_cyc), .req_valid(m_v), .req_ready(m_rdy), .req_src_addr(m_sa),
    .req_dst_addr(m_da), .req_beats(m_bt), .req_strb(m_st), .req_row_end(m_re),
    .req_xfer_end(m_xe), .xfer_done(m_done));

  burst_walk2d #(.ADDR_W(32), .LEN_W(12), .ROWS_W(6), .DATA_BYTES(4),
                 .MAX_BURST_BYTES(16), .PROTO(2), .EN_2D(0)) dut_flat_i (
    .clk(clk), .rst(rst), .enable(enable), .desc_valid(f_dv), .desc_ready(f_dr),
    .desc_src_base(d_src), .desc_dst_base(d_dst), .desc_row_len_m1(d_len),
    .desc_row_cnt_m1(d_cnt), .desc_src_stride(d_ss), .desc_dst_stride(d_ds),
    .desc_cyclic(d_cyc), .req_valid(f_v), .req_ready(f_rdy), .req_src_addr(f_sa),
    .req_dst_addr(f_da), .req_beats(f_bt), .req_strb(f_st), .req_row_end(f_re),
    .req_xfer_end(f_xe), .xfer_done(f_done));

  // Selected-instance views
  wire        v    = sel ? f_v    : m_v;
  wire        dr   = sel ? f_dr   : m_dr;
  wire        done = sel ? f_done : m_done;
  wire [31:0] sa   = sel ? f_sa   : m_sa;
  wire [31:0] da   = sel ? f_da   : m_da;
  wire [31:0] bt   = sel ? 32'(f_bt) : 32'(m_bt);
  wire [3:0]  st   = sel ? f_st   : m_st;
  wire        re   = sel ? f_re   : m_re;
  wire        xe   = sel ? f_xe   : m_xe;

  task automatic set_rdy(input logic val);
    if (sel) f_rdy = val; else m_rdy = val;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic submit(input logic [31:0] s, input logic [31:0] d, input int len_m1,
                        input int cnt_m1, input logic [31:0] ss, input logic [31:0] ds,
                        input logic cyc);
    @(negedge clk);
    d_src = s; d_dst = d; d_len = 12'(len_m1); d_cnt = 6'(cnt_m1);
    d_ss = ss; d_ds = ds; d_cyc = cyc;
    if (sel) f_dv = 1'b1; else m_dv = 1'b1;
    #1;
    while (!dr) begin @(negedge clk); #1; end
    @(negedge clk);
    f_dv = 1'b0; m_dv = 1'b0;
  endtask

  // Walks the expected burst list from the requirements and compares each
  // accepted request. limit < 0 means the whole transfer.
  task automatic consume(input string req, input logic [31:0] s, input logic [31:0] d,
                         input int len_m1, input int cnt_m1, input logic [31:0] ss,
                         input logic [31:0] ds, input int passes, input int mode,
                         input bit want_done, input int limit);
    int burst   = sel ? 16 : 64;
    int rows    = sel ? 1 : cnt_m1 + 1;
    int taken   = 0;
    bit pv      = 0;
    bit prdy    = 0;
    bit saw_done = 0;
    logic [31:0] p_sa = '0, p_da = '0, p_bt = '0;
    logic [3:0]  p_st = '0;
    for (int p = 0; p < passes; p++) begin
      for (int r = 0; r < rows; r++) begin
        int rem = len_m1 + 1;
        int off = 0;
        while (rem > 0) begin
          int b = (rem > burst) ? burst : rem;
          int k = b % 4;
          logic [31:0] e_sa = (s & ~32'h3) + 32'(r) * (ss & ~32'h3) + 32'(off);
          logic [31:0] e_da = (d & ~32'h3) + 32'(r) * (ds & ~32'h3) + 32'(off);
          logic [3:0]  e_st = (k == 0) ? 4'hF : 4'((1 << k) - 1);
          bit          e_re = (rem == b);
          bit          e_xe = e_re && (r == rows - 1);
          bit          got  = 0;
          if (limit >= 0 && taken >= limit) return;
          while (!got) begin
            @(negedge clk);
            set_rdy((mode == 0) ? 1'b1 : ((cyc_cnt % 3) != 0));
            #1;
            if (done) saw_done = 1;
            if (pv && !prdy) begin
              if (!(v && sa == p_sa && da == p_da && bt == p_bt && st == p_st)) begin
                chk("R9", "held request changed", {v, sa}, {1'b1, p_sa});
              end
            end
            pv = v; prdy = sel ? f_rdy : m_rdy;
            p_sa = sa; p_da = da; p_bt = bt; p_st = st;
            got = v && prdy;
          end
          chk(req, "src addr", sa, e_sa);
          chk(req, "dst addr", da, e_da);
          chk(req, "beats", bt, (b + 3) / 4);
          chk(req, "strb", st, e_st);
          chk(req, "row_end/xfer_end", {re, xe}, {e_re, e_xe});
          taken++;
          off += b;
          rem -= b;
        end
      end
    end
    if (!want_done) chk("R7", "no done during cyclic passes", saw_done, 0);
    @(negedge clk);
    set_rdy(1'b0);
    #1;
    if (want_done) begin
      chk("R10", "done after final burst", {done, v}, 2'b10);
      @(negedge clk); #1;
      chk("R10", "done single cycle", done, 0);
    end
  endtask

  task automatic t_reset;
    sel = 0;
    #1;
    chk("R11", "valid/done after reset", {m_v, m_done, f_v, f_done}, 4'b0000);
    chk("R11", "desc_ready with enable", {m_dr, f_dr}, 2'b11);
    @(negedge clk); enable = 1'b0; #1;
    chk("R8", "desc_ready with enable low", {m_dr, f_dr}, 2'b00);
    m_dv = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "descriptor refused while disabled", m_v, 0);
    m_dv = 1'b0; enable = 1'b1;
  endtask

  task automatic t_rows;
    sel = 0;
    submit(32'h1003, 32'h2002, 101, 2, 32'h201, 32'h181, 1'b0);
    consume("R1 R2 R4 R5 R6", 32'h1003, 32'h2002, 101, 2, 32'h201, 32'h181, 1, 0, 1, -1);
  endtask

  task automatic t_backpressure;
    sel = 0;
    submit(32'h8000, 32'h9000, 199, 1, 32'h400, 32'h100, 1'b0);
    consume("R9 R5", 32'h8000, 32'h9000, 199, 1, 32'h400, 32'h100, 1, 1, 1, -1);
  endtask

  task automatic t_small;
    sel = 0;
    submit(32'h40, 32'h80, 0, 0, 32'h0, 32'h0, 1'b0);
    consume("R6 single byte", 32'h40, 32'h80, 0, 0, 32'h0, 32'h0, 1, 0, 1, -1);
    submit(32'h100, 32'h300, 63, 0, 32'h0, 32'h0, 1'b0);
    consume("R6 R5 exact burst", 32'h100, 32'h300, 63, 0, 32'h0, 32'h0, 1, 0, 1, -1);
  endtask

  task automatic t_cyclic;
    sel = 0;
    submit(32'h5000, 32'h6000, 63, 1, 32'h80, 32'h40, 1'b1);
    consume("R7", 32'h5000, 32'h6000, 63, 1, 32'h80, 32'h40, 3, 0, 0, -1);
    enable = 1'b0;
    repeat (2) begin @(negedge clk); #1; end
    chk("R8", "presented request held after disable", {m_v, m_sa}, {1'b1, 32'h5000});
    m_rdy = 1'b1;
    @(negedge clk); m_rdy = 1'b0; #1;
    chk("R8", "nothing after last accepted", {m_v, m_done}, 2'b00);
    repeat (4) @(negedge clk);
    #1;
    chk("R7", "cyclic stop without done", {m_v, m_done}, 2'b00);
    enable = 1'b1;
  endtask

  task automatic t_stop;
    sel = 0;
    submit(32'hA000, 32'hB000, 199, 1, 32'h400, 32'h400, 1'b0);
    consume("R8 lead", 32'hA000, 32'hB000, 199, 1, 32'h400, 32'h400, 1, 0, 0, 2);
    // third burst is being presented; drop enable while stalled
    @(negedge clk); m_rdy = 1'b0; enable = 1'b0; #1;
    repeat (2) begin @(negedge clk); #1; end
    chk("R8", "stalled request kept", {m_v, m_sa, 32'(m_bt)}, {1'b1, 32'hA080, 32'd16});
    m_rdy = 1'b1;
    @(negedge clk); m_rdy = 1'b0; #1;
    chk("R8", "stop at burst boundary", {m_v, m_done}, 2'b00);
    repeat (5) @(negedge clk);
    #1;
    chk("R8", "still no requests", m_v, 0);
    enable = 1'b1; #1;
    chk("R8", "idle again after stop", {m_dr, m_v}, 2'b10);
  endtask

  task automatic t_flat;
    sel = 1;
    submit(32'hC001, 32'hD003, 36, 5, 32'h1000, 32'h1000, 1'b0);
    consume("R3 R5 R6", 32'hC001, 32'hD003, 36, 5, 32'h1000, 32'h1000, 1, 1, 1, -1);
    sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rows();
    t_backpressure();
    t_small();
    t_cyclic();
    t_stop();
    t_flat();
    repeat (3) @(negedge clk);
    report();
  end

endmodule